// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block is the sending half of an asynchronous line interface. Software sees two 16-bit locations on a simple register bus. One is a control/status word: ready flag, interrupt enable, loopback and break. The other is a write-only character register. A written character waits in a one-deep holding register and moves into the frame shifter as soon as the shifter is free. The ready flag therefore drops for a single clock after a write into an idle transmitter, and stays low for roughly a frame when the shifter is already busy.

Each frame is a start bit, 5 to 8 data bits sent least significant bit first, an optional odd or even parity bit, and 1, 1.5 or 2 stop bits. The line idles at mark (1). Bit timing comes from `tick_i`, a single-cycle strobe at twice the bit rate. Every bit lasts two strobes, and a stop setting of 1.5 lasts three. The block also steers the receive path: in loopback it hands the transmit line and the transmit strobe to the receiver in place of the external pin and receive strobe. It also merges the receive section's interrupt request with its own, giving the receive side priority.

Top module: `sertx_core`

## Requirements
- R1: After reset the status word reads 0x0080 (only ready set), `txd_o` is 1 and `irq_o` is 0.
- R2: A write to the character register (`bus_sel_i`=1) clears ready (status bit 7) on the next clock. If the shifter was idle and the holder empty, ready is set again one clock later. A write made while a frame is being sent keeps ready clear until that frame's last strobe.
- R3: Each frame is a 0 start bit, then N data bits LSB first, with N = 5 + `cfg_bits_i` (0..3 → 5..8). When `cfg_par_en_i` is 1, a parity bit follows that makes the count of ones in data plus parity even (`cfg_par_odd_i`=0) or odd (`cfg_par_odd_i`=1). The stop level is 1.
- R4: When frames are sent back to back, one start edge follows the previous one by exactly L strobe periods, where L = 2·(1+N+parity) + S. S is 2, 3 or 4 for `cfg_stop_i` = 0, 1 or 2/3.
- R5: Bits 15..N of a written character do not reach the line.
- R6: While break (status bit 0) is 1, `txd_o` is 0. Ready keeps clearing on writes and setting as characters are taken and sent.
- R7: While loopback (status bit 2) is 1, `rxd_o` equals `txd_o` and `rx_tick_o` equals `tick_i`. Otherwise `rxd_o` equals `rxd_ext_i` and `rx_tick_o` equals `rx_tick_ext_i`.
- R8: The transmit section requests an interrupt exactly when ready and enable (status bit 6) are both 1.
- R9: When `rx_irq_req_i` is 1, `irq_o` is 1 and `irq_tx_o` is 0. `irq_tx_o` is 1 only when the transmit request is the one being served.
- R10: A status write sets break, loopback and enable from bits 0, 2 and 6. Every other status bit apart from ready reads 0, and the character location reads 0.
- R11: With no frame in progress and break off, `txd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-bit strobe, one cycle wide |
| bus_sel_i | input | 1 | 0 = status word, 1 = character register |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the selected location |
| cfg_bits_i | input | 2 | Character length code, length = 5 + code |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop_i | input | 2 | Stop length: 0 = 1, 1 = 1.5, 2/3 = 2 bits |
| txd_o | output | 1 | Serial line out |
| rxd_ext_i | input | 1 | External serial line in |
| rx_tick_ext_i | input | 1 | Receive strobe from the external rate source |
| rxd_o | output | 1 | Serial data handed to the receiver |
| rx_tick_o | output | 1 | Strobe handed to the receiver |
| rx_irq_req_i | input | 1 | Interrupt request from the receive section |
| irq_o | output | 1 | Merged interrupt request |
| irq_tx_o | output | 1 | 1 when the transmit request is the one being served |

## Verification
The hardest situation to reach is two characters in flight at once, with one in the shifter and one in the holder, and above all three such frames in a row. Only then is the start-to-start spacing fixed by the strobe grid rather than by when software happened to write. The stimulus reaches it by writing a second character one clock after the first, when ready has already come back. It then waits on ready before each further write and measures the gap between the second and third start edges. Break is checked the same way with two queued characters, so the ready flag is seen cycling while the line is held at space.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int REG_W     = 16;
  localparam int CHAR_W    = 8;
  localparam int MIN_BITS  = CHAR_W - 3;
  localparam int FRAME_W   = CHAR_W + 4;             // start + data + parity + two stop
  localparam int HCNT_W    = $clog2(2 * FRAME_W) + 1;
  localparam int IDX_W     = HCNT_W - 1;
  localparam int PAD_W     = 1 << IDX_W;
  localparam int RDY_POS   = 7;
  localparam int IE_POS    = 6;
  localparam int MAINT_POS = 2;
  localparam int BRK_POS   = 0;

  typedef struct packed {
    logic [1:0] bits;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop;
  } line_cfg_t;

  function automatic int char_len(logic [1:0] code);
    return MIN_BITS + int'(code);
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(logic [CHAR_W-1:0] d, line_cfg_t c);
    logic [FRAME_W-1:0] f;
    logic               p;
    int                 n;
    n    = char_len(c.bits);
    f    = '1;
    f[0] = 1'b0;
    p    = c.par_odd;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < n) begin
        f[i+1] = d[i];
        p      = p ^ d[i];
      end
    end
    for (int i = MIN_BITS; i <= CHAR_W; i++) begin
      if (c.par_en && i == n) f[i+1] = p;
    end
    return f;
  endfunction

  function automatic logic [HCNT_W-1:0] frame_halves(line_cfg_t c);
    int h;
    h = 2 * (1 + char_len(c.bits) + int'(c.par_en));
    case (c.stop)
      2'd0:    h = h + 2;
      2'd1:    h = h + 3;
      default: h = h + 4;
    endcase
    return h[HCNT_W-1:0];
  endfunction
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
  import sertx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              take_i,
  output logic              ready_o,
  output logic [CHAR_W-1:0] hold_o,
  output logic              brk_o,
  output logic              maint_o,
  output logic              ie_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic full_q;
  logic unused_hi;
  assign unused_hi = ^wdata_i[REG_W-1:CHAR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      hold_o  <= '0;
      brk_o   <= 1'b0;
      maint_o <= 1'b0;
      ie_o    <= 1'b0;
    end else begin
      if (wr_i && sel_i) begin
        hold_o <= wdata_i[CHAR_W-1:0];
        full_q <= 1'b1;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
      if (wr_i && !sel_i) begin
        brk_o   <= wdata_i[BRK_POS];
        maint_o <= wdata_i[MAINT_POS];
        ie_o    <= wdata_i[IE_POS];
      end
    end
  end

  assign ready_o = !full_q;

  always_comb begin
    rdata_o = '0;
    if (!sel_i) begin
      rdata_o[RDY_POS]   = ready_o;
      rdata_o[IE_POS]    = ie_o;
      rdata_o[MAINT_POS] = maint_o;
      rdata_o[BRK_POS]   = brk_o;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] char_i,
  input  line_cfg_t         cfg_i,
  output logic              busy_o,
  output logic              line_o
);
  logic [PAD_W-1:0]  frame_q;
  logic [HCNT_W-1:0] hcnt_q, hlen_q;
  logic [IDX_W-1:0]  bit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      hcnt_q  <= '0;
      hlen_q  <= '0;
      frame_q <= '1;
    end else if (load_i) begin
      busy_o  <= 1'b1;
      hcnt_q  <= '0;
      hlen_q  <= frame_halves(cfg_i);
      frame_q <= {{(PAD_W-FRAME_W){1'b1}}, build_frame(char_i, cfg_i)};
    end else if (busy_o && tick_i) begin
      if (hcnt_q == hlen_q - 1'b1) busy_o <= 1'b0;
      else                         hcnt_q <= hcnt_q + 1'b1;
    end
  end

  // two half-bit strobes per cell; past the frame the padding keeps mark
  assign bit_idx = hcnt_q[HCNT_W-1:1];
  assign line_o  = busy_o ? frame_q[bit_idx] : 1'b1;
endmodule

// File: rtl/sertx_route.sv
module sertx_route (
  input  logic brk_i,
  input  logic maint_i,
  input  logic ie_i,
  input  logic ready_i,
  input  logic line_i,
  input  logic tick_i,
  input  logic rxd_ext_i,
  input  logic rx_tick_ext_i,
  input  logic rx_irq_i,
  output logic txd_o,
  output logic rxd_o,
  output logic rx_tick_o,
  output logic irq_o,
  output logic irq_tx_o
);
  logic tx_req;
  logic line_out;

  assign line_out  = brk_i ? 1'b0 : line_i;
  assign txd_o     = line_out;
  assign rxd_o     = maint_i ? line_out : rxd_ext_i;
  assign rx_tick_o = maint_i ? tick_i : rx_tick_ext_i;

  assign tx_req   = ready_i & ie_i;
  assign irq_o    = rx_irq_i | tx_req;
  assign irq_tx_o = tx_req & !rx_irq_i;
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  input  logic [1:0]  cfg_bits_i,
  input  logic        cfg_par_en_i,
  input  logic        cfg_par_odd_i,
  input  logic [1:0]  cfg_stop_i,
  output logic        txd_o,
  input  logic        rxd_ext_i,
  input  logic        rx_tick_ext_i,
  output logic        rxd_o,
  output logic        rx_tick_o,
  input  logic        rx_irq_req_i,
  output logic        irq_o,
  output logic        irq_tx_o
);
  logic              tx_ready, sh_busy, sh_line, take;
  logic              st_brk, st_maint, st_ie;
  logic [CHAR_W-1:0] hold_char;
  line_cfg_t         cfg;

  assign cfg  = '{bits: cfg_bits_i, par_en: cfg_par_en_i, par_odd: cfg_par_odd_i, stop: cfg_stop_i};
  assign take = !tx_ready && !sh_busy;

  sertx_regs i_regs (
    .clk_i, .rst_ni,
    .wr_i(bus_wr_i), .sel_i(bus_sel_i), .wdata_i(bus_wdata_i),
    .take_i(take), .ready_o(tx_ready), .hold_o(hold_char),
    .brk_o(st_brk), .maint_o(st_maint), .ie_o(st_ie), .rdata_o(bus_rdata_o)
  );

  sertx_shift i_shift (
    .clk_i, .rst_ni, .tick_i,
    .load_i(take), .char_i(hold_char), .cfg_i(cfg),
    .busy_o(sh_busy), .line_o(sh_line)
  );

  sertx_route i_route (
    .brk_i(st_brk), .maint_i(st_maint), .ie_i(st_ie), .ready_i(tx_ready),
    .line_i(sh_line), .tick_i, .rxd_ext_i, .rx_tick_ext_i,
    .rx_irq_i(rx_irq_req_i), .txd_o, .rxd_o, .rx_tick_o, .irq_o, .irq_tx_o
  );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_sel_i,
  input logic bus_wr_i,
  input logic brk_i,
  input logic maint_i,
  input logic ie_i,
  input logic ready_i,
  input logic busy_i,
  input logic txd_i,
  input logic rxd_i,
  input logic rx_irq_i,
  input logic irq_i,
  input logic irq_tx_i
);
  AST_DATA_WRITE_CLEARS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_sel_i) |=> !ready_i); // R2
  AST_IDLE_READY_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_sel_i && ready_i && !busy_i) |=> ##1 ready_i); // R2
  AST_BREAK_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_i); // R6
  AST_LOOP_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    maint_i |-> (rxd_i == txd_i)); // R7
  AST_TX_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && ie_i && !rx_irq_i) |-> (irq_i && irq_tx_i)); // R8
  AST_RX_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_i |-> (irq_i && !irq_tx_i)); // R9
  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !brk_i) |-> txd_i); // R11
endmodule

bind sertx_core sertx_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
  .brk_i(st_brk), .maint_i(st_maint), .ie_i(st_ie), .ready_i(tx_ready),
  .busy_i(sh_busy), .txd_i(txd_o), .rxd_i(rxd_o), .rx_irq_i(rx_irq_req_i),
  .irq_i(irq_o), .irq_tx_i(irq_tx_o)
);

// File: tb/test_sertx_core.sv
module test_sertx_core;
  localparam int P = 8;  // clocks per half-bit strobe

  logic        clk_i = 0, rst_ni = 0, tick_i = 0;
  logic        bus_sel_i = 0, bus_wr_i = 0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [1:0]  cfg_bits_i = 2'd3;
  logic        cfg_par_en_i = 0, cfg_par_odd_i = 0;
  logic [1:0]  cfg_stop_i = 2'd0;
  logic        txd_o, rxd_ext_i = 1, rx_tick_ext_i = 0, rxd_o, rx_tick_o;
  logic        rx_irq_req_i = 0, irq_o, irq_tx_o;

  sertx_core i_sertx_core (.*);

  always #10 clk_i = ~clk_i;

  int     n_run = 0, n_fail = 0, tdiv = 0;
  longint cyc = 0;
  bit     mon_en = 1;
  logic [15:0] q_vec[$];
  int          q_nb[$];
  string       q_tag[$];
  longint      st_t[$];

  always @(posedge clk_i) cyc++;
  always @(negedge clk_i) begin
    tdiv   = (tdiv == P-1) ? 0 : tdiv + 1;
    tick_i = (tdiv == 0);
  end

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input bit sel, input logic [15:0] d);
    @(negedge clk_i);
    bus_sel_i = sel; bus_wdata_i = d; bus_wr_i = 1;
    @(negedge clk_i);
    bus_wr_i = 0; bus_sel_i = 0;
    #1;
  endtask

  // expected bits: [0] start, then data LSB first, then parity
  task automatic push_exp(input logic [15:0] d, input string tag);
    logic [15:0] v; int n; logic p;
    n = 5 + int'(cfg_bits_i); v = '0; p = cfg_par_odd_i;
    for (int i = 0; i < n; i++) begin v[i+1] = d[i]; p = p ^ d[i]; end
    if (cfg_par_en_i) v[n+1] = p;
    q_vec.push_back(v);
    q_nb.push_back(1 + n + int'(cfg_par_en_i));
    q_tag.push_back(tag);
  endtask

  task automatic send(input logic [15:0] d, input string tag);
    int g = 0;
    while (!bus_rdata_o[7] && g < 2000) begin step(); g++; end
    push_exp(d, tag);
    bwrite(1, d);
  endtask

  task automatic drain();
    int g = 0;
    while ((q_nb.size() != 0 || !bus_rdata_o[7]) && g < 5000) begin step(); g++; end
    repeat (6*P) step();
  endtask

  // monitor: decodes frames on the line and compares against the queue
  initial begin
    forever begin
      int nb, cnt; bit pend; logic [15:0] got;
      do step(); while (!(mon_en && txd_o === 1'b0));
      st_t.push_back(cyc);
      if (q_nb.size() == 0) begin
        chk(0, "R3 unexpected frame", 0, 1);
        while (txd_o !== 1'b1) step();
      end else begin
        nb = q_nb[0]; got = '0; cnt = 0; pend = 0;
        while (cnt < 2*nb) begin
          step();
          if (pend) begin got[(cnt-1)/2] = txd_o; pend = 0; end
          if (tick_i) begin cnt++; if (cnt % 2 == 1) pend = 1; end
        end
        step();
        chk(txd_o === 1'b1, {q_tag[0], " stop level R3"}, txd_o, 1);
        chk(got == q_vec[0], q_tag[0], got, q_vec[0]);
        void'(q_vec.pop_front()); void'(q_nb.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired: actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c, mism, saw0, viol;
    repeat (3) step();
    chk(bus_rdata_o == 16'h0080, "R1 status in reset", bus_rdata_o, 16'h0080);
    rst_ni = 1;
    step();
    chk(bus_rdata_o == 16'h0080, "R1 status after reset", bus_rdata_o, 16'h0080);
    chk(txd_o === 1'b1, "R1 line at mark", txd_o, 1);
    chk(irq_o === 1'b0, "R1 no interrupt", irq_o, 0);

    // R10 status register
    mon_en = 0;
    bwrite(0, 16'hFFFF);
    chk(bus_rdata_o == 16'h00C5, "R10 status bits", bus_rdata_o, 16'h00C5);
    bus_sel_i = 1; #1;
    chk(bus_rdata_o == 16'h0000, "R10 char location reads 0", bus_rdata_o, 0);
    bus_sel_i = 0;
    bwrite(0, 16'h0000);
    chk(bus_rdata_o == 16'h0080, "R10 status cleared", bus_rdata_o, 16'h0080);
    mon_en = 1;

    // R3 / R5 frame formats
    send(16'h0055, "R3 8N1 0x55");
    send(16'h12A3, "R5 8N1 upper byte ignored");
    drain();
    cfg_bits_i = 2'd2; cfg_par_en_i = 1; cfg_par_odd_i = 0;
    send(16'h0041, "R3 7E 0x41");
    drain();
    cfg_bits_i = 2'd0; cfg_par_odd_i = 1;
    send(16'hA5F3, "R5 5O high bits dropped");
    drain();
    cfg_bits_i = 2'd1;
    send(16'h002C, "R3 6O 0x2C");
    drain();
    cfg_bits_i = 2'd3; cfg_par_odd_i = 0;
    send(16'h00FF, "R3 8E 0xFF");
    drain();

    // R11 idle mark
    for (int i = 0; i < 3; i++) begin
      repeat (5) step();
      chk(txd_o === 1'b1, "R11 idle mark", txd_o, 1);
    end

    // R2 ready timing
    cfg_par_en_i = 0; cfg_stop_i = 2'd0;
    push_exp(16'h005A, "R2 first char");
    bwrite(1, 16'h005A);
    chk(bus_rdata_o[7] == 1'b0, "R2 ready drops", bus_rdata_o[7], 0);
    step();
    chk(bus_rdata_o[7] == 1'b1, "R2 ready back next clock", bus_rdata_o[7], 1);
    push_exp(16'h003C, "R2 second char");
    bwrite(1, 16'h003C);
    chk(bus_rdata_o[7] == 1'b0, "R2 ready drops again", bus_rdata_o[7], 0);
    repeat (4*P) step();
    chk(bus_rdata_o[7] == 1'b0, "R2 ready held while busy", bus_rdata_o[7], 0);
    c = 0;
    while (!bus_rdata_o[7] && c < 1000) begin step(); c++; end
    chk(c > 100 && c < 200, "R2 ready returns at frame end", c, 130);
    drain();

    // R4 stop length via back-to-back spacing
    for (int sc = 0; sc < 3; sc++) begin
      longint exp_gap, gap;
      cfg_stop_i = sc[1:0];
      st_t.delete();
      send(16'h0011, "R4 frame a");
      send(16'h0022, "R4 frame b");
      send(16'h0033, "R4 frame c");
      drain();
      exp_gap = longint'((18 + 2 + sc) * P);
      gap = (st_t.size() == 3) ? st_t[2] - st_t[1] : -1;
      chk(gap == exp_gap, "R4 start spacing", gap, exp_gap);
    end
    cfg_stop_i = 2'd0;

    // R8 / R9 interrupts
    bwrite(0, 16'h0040);
    chk(irq_o && irq_tx_o, "R8 tx request", {irq_o, irq_tx_o}, 2'b11);
    rx_irq_req_i = 1; #1;
    chk(irq_o && !irq_tx_o, "R9 receive served first", {irq_o, irq_tx_o}, 2'b10);
    rx_irq_req_i = 0; #1;
    push_exp(16'h0099, "R8 char");
    bwrite(1, 16'h0099);
    chk(irq_o === 1'b0, "R8 no request while not ready", irq_o, 0);
    step();
    chk(irq_o === 1'b1, "R8 request with ready back", irq_o, 1);
    bwrite(0, 16'h0000);
    chk(irq_o === 1'b0, "R8 disabled", irq_o, 0);
    rx_irq_req_i = 1; #1;
    chk(irq_o && !irq_tx_o, "R9 receive alone", {irq_o, irq_tx_o}, 2'b10);
    rx_irq_req_i = 0;
    drain();

    // R7 loopback
    bwrite(0, 16'h0004);
    rxd_ext_i = 1; rx_tick_ext_i = 0;
    send(16'h0000, "R7 loopback frame");
    mism = 0; saw0 = 0;
    repeat (30*P) begin
      step();
      if (rxd_o !== txd_o || rx_tick_o !== tick_i) mism++;
      if (rxd_o === 1'b0) saw0++;
    end
    chk(mism == 0, "R7 loop follows transmitter", mism, 0);
    chk(saw0 > 0, "R7 space seen through loop", saw0, 1);
    drain();
    bwrite(0, 16'h0000);
    rxd_ext_i = 0; rx_tick_ext_i = 1; #1;
    chk(rxd_o === 1'b0 && rx_tick_o === 1'b1, "R7 external path", {rxd_o, rx_tick_o}, 2'b01);
    rxd_ext_i = 1; rx_tick_ext_i = 0; #1;
    chk(rxd_o === 1'b1 && rx_tick_o === 1'b0, "R7 external path idle", {rxd_o, rx_tick_o}, 2'b10);

    // R6 break
    mon_en = 0;
    bwrite(0, 16'h0001);
    chk(txd_o === 1'b0, "R6 line spaced", txd_o, 0);
    bwrite(1, 16'h007F);
    chk(bus_rdata_o[7] == 1'b0, "R6 ready drops in break", bus_rdata_o[7], 0);
    step();
    chk(bus_rdata_o[7] == 1'b1, "R6 ready cycles in break", bus_rdata_o[7], 1);
    bwrite(1, 16'h0080);
    c = 0; viol = 0;
    while (!bus_rdata_o[7] && c < 400) begin
      step(); c++;
      if (txd_o !== 1'b0) viol++;
    end
    chk(bus_rdata_o[7] == 1'b1, "R6 ready returns in break", bus_rdata_o[7], 1);
    chk(viol == 0, "R6 line held at space", viol, 0);
    repeat (30*P) step();
    chk(txd_o === 1'b0, "R6 still spaced after frames", txd_o, 0);
    bwrite(0, 16'h0000);
    step();
    chk(txd_o === 1'b1, "R6 mark after break off", txd_o, 1);
    mon_en = 1;

    repeat (10) step();
    chk(q_nb.size() == 0, "R3 all frames seen", q_nb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule